// File: doc/BRIEF.md
# Shared-Memory Slot Arbiter with Spare-Slot Reuse

This block sets which processor core may use a shared memory port in each clock cycle. A slot pointer steps through the cores in a fixed circular order, one core per clock. The core the pointer selects is that cycle's owner. When the owner requests, it always gets the cycle. When the owner is idle, the cycle is spare. A spare cycle can go to another core only if that core has opted in to take spare cycles ("hungry" cores). Cores that have not opted in see exactly the same access timing as a plain round-robin scheme, whatever the other cores do.

Each core has a request line and a hungry-enable bit. A single global bit turns off all spare-cycle reuse, so that software can be tested at guaranteed bandwidth only. The decision is registered. The grant for a cycle appears one clock after the edge that sampled the requests, as a one-hot vector together with the binary index of the winner.

Top module: `slot_share_arbiter`

## Requirements
- R1: While reset is high, the grant vector and grant index are all zero. The first clock edge after reset is released serves slot 0.
- R2: The slot pointer advances by exactly one core per clock. Core k owns the k-th edge after reset, taken modulo N (N = 8 by default), and the pointer wraps from N-1 to 0.
- R3: If the owner of the current slot requests at an edge, the next cycle grants that owner, whatever the other inputs are.
- R4: A core whose hungry bit was clear at the previous edge is never granted a slot it does not own.
- R5: A core is granted another core's slot only when that slot's owner is not requesting at the deciding edge.
- R6: When several hungry cores request a spare slot, the winner is the first requesting hungry core found by searching owner+1, owner+2, and so on, wrapping past N-1 to 0.
- R7: While the global share-off bit is high at an edge, only the slot owner can be granted at that edge.
- R8: At most one grant bit is high in any cycle. If the owner is idle and no hungry core requests, the grant vector is zero.
- R9: A hungry-enable bit is sampled into a register, so a change becomes usable at the edge after the one that samples it.
- R10: Grant bit i means core i holds the cycle, and the grant index equals i. When no core is granted, the grant index is 0. Each grant lasts exactly one cycle and is never withdrawn inside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N | Request per core, bit i for core i |
| hungry_i | input | N | Spare-slot opt-in per core, bit i for core i |
| share_off_i | input | 1 | High: no spare-slot reuse |
| grant_o | output | N | One-hot grant, registered |
| grant_idx_o | output | W = clog2(N) | Binary index of the granted core, 0 when none |

## Verification
The properties assume that the inputs are stable around each rising edge and that reset is held for at least one edge before the first checked cycle. They also assume that the core count N is at least 2, so the slot pointer has a real width. The bench changes every input only on the falling clock edge and holds reset across several edges. It also shifts each hungry-bit change by one step in its own reference model, matching the registered opt-in, so expected and observed grants refer to the same decision edge.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;

  // Circular addition used for slot pointers and the spare search.
  function automatic int unsigned wrap_add(int unsigned base, int unsigned step,
                                           int unsigned count);
    return (base + step) % count;
  endfunction

  // Kind of decision taken for the current slot.
  typedef enum logic [1:0] {
    PICK_NONE  = 2'd0,
    PICK_OWNER = 2'd1,
    PICK_SPARE = 2'd2
  } pick_kind_e;

endpackage

// File: rtl/slot_rotor.sv
// Circular slot pointer: one core per clock.
module slot_rotor #(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] slot_o
);
  localparam logic [W-1:0] LAST = W'(N - 1);

  always_ff @(posedge clk) begin
    if (rst)                 slot_o <= '0;
    else if (slot_o == LAST) slot_o <= '0;
    else                     slot_o <= slot_o + 1'b1;
  end
endmodule

// File: rtl/spare_picker.sv
// Finds the first candidate after the owner, searching upward with wrap.
module spare_picker
  import slot_arb_pkg::*;
#(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [W-1:0] slot_i,
  input  logic [N-1:0] cand_i,
  output logic         found_o,
  output logic [W-1:0] pick_o
);
  logic [N-1:0] rot;

  // rot[j] is the candidate bit of the core j positions after the owner.
  for (genvar j = 0; j < N; j++) begin : g_rot
    always_comb rot[j] = cand_i[W'(wrap_add(int'(slot_i), j, N))];
  end

  always_comb begin
    found_o = 1'b0;
    pick_o  = '0;
    for (int j = 1; j < N; j++) begin
      if (!found_o && rot[j]) begin
        found_o = 1'b1;
        pick_o  = W'(wrap_add(int'(slot_i), j, N));
      end
    end
  end
endmodule

// File: rtl/grant_stage.sv
// Output register: one-hot grant plus binary index.
module grant_stage #(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take_i,
  input  logic [W-1:0] idx_i,
  output logic [N-1:0] grant_o,
  output logic [W-1:0] grant_idx_o
);
  localparam logic [N-1:0] ONE = N'(1);

  always_ff @(posedge clk) begin
    if (rst || !take_i) begin
      grant_o     <= '0;
      grant_idx_o <= '0;
    end else begin
      grant_o     <= ONE << idx_i;
      grant_idx_o <= idx_i;
    end
  end
endmodule

// File: rtl/slot_share_arbiter.sv
module slot_share_arbiter
  import slot_arb_pkg::*;
#(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] hungry_i,
  input  logic         share_off_i,
  output logic [N-1:0] grant_o,
  output logic [W-1:0] grant_idx_o
);
  logic [W-1:0] slot_q;
  logic [N-1:0] hungry_q;
  logic [N-1:0] spare_cand;
  logic         spare_found;
  logic [W-1:0] spare_idx;
  logic         owner_req;
  pick_kind_e   kind;
  logic [W-1:0] win_idx;

  // Opt-in bits are registered: a change counts from the following edge.
  always_ff @(posedge clk) begin
    if (rst) hungry_q <= '0;
    else     hungry_q <= hungry_i;
  end

  slot_rotor #(.N(N)) u_rotor (
    .clk    (clk),
    .rst    (rst),
    .slot_o (slot_q)
  );

  always_comb begin
    owner_req  = req_i[slot_q];
    spare_cand = share_off_i ? '0 : (req_i & hungry_q);
  end

  spare_picker #(.N(N)) u_picker (
    .slot_i  (slot_q),
    .cand_i  (spare_cand),
    .found_o (spare_found),
    .pick_o  (spare_idx)
  );

  // The owner always wins its slot; spares are used only when the owner is idle.
  always_comb begin
    if (owner_req) begin
      kind    = PICK_OWNER;
      win_idx = slot_q;
    end else if (spare_found) begin
      kind    = PICK_SPARE;
      win_idx = spare_idx;
    end else begin
      kind    = PICK_NONE;
      win_idx = '0;
    end
  end

  grant_stage #(.N(N)) u_grant (
    .clk         (clk),
    .rst         (rst),
    .take_i      (kind != PICK_NONE),
    .idx_i       (win_idx),
    .grant_o     (grant_o),
    .grant_idx_o (grant_idx_o)
  );
endmodule

// File: rtl/slot_share_rules.sv
// Property checker, bound into the arbiter.
module slot_share_rules #(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] req_i,
  input logic [N-1:0] hung_q,
  input logic         share_off_i,
  input logic [W-1:0] slot,
  input logic [N-1:0] grant_o,
  input logic [W-1:0] grant_idx_o
);
  localparam logic [W-1:0] LAST = W'(N - 1);
  localparam logic [N-1:0] ONE  = N'(1);

  logic         p_valid;
  logic [W-1:0] p_slot;
  logic [N-1:0] p_req;
  logic [N-1:0] p_hung;
  logic         p_off;
  logic [N-1:0] own_oh;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_valid <= 1'b0;
      p_slot  <= '0;
      p_req   <= '0;
      p_hung  <= '0;
      p_off   <= 1'b0;
    end else begin
      p_valid <= 1'b1;
      p_slot  <= slot;
      p_req   <= req_i;
      p_hung  <= hung_q;
      p_off   <= share_off_i;
    end
  end

  always_comb own_oh = ONE << p_slot;

  assert_slot_step_R2: assert property (@(posedge clk) disable iff (rst)
    p_valid |-> slot == ((p_slot == LAST) ? '0 : p_slot + 1'b1));

  assert_owner_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (p_valid && p_req[p_slot]) |-> grant_o == own_oh);

  assert_foreign_needs_optin_R4: assert property (@(posedge clk) disable iff (rst)
    (p_valid && (grant_o & ~own_oh) != '0) |-> (grant_o & ~p_hung) == '0);

  assert_foreign_owner_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (p_valid && (grant_o & ~own_oh) != '0) |-> !p_req[p_slot]);

  assert_share_off_R7: assert property (@(posedge clk) disable iff (rst)
    (p_valid && p_off) |-> (grant_o & ~own_oh) == '0);

  assert_single_grant_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));

  assert_idle_no_grant_R8: assert property (@(posedge clk) disable iff (rst)
    (p_valid && !p_req[p_slot] && (p_req & p_hung) == '0) |-> grant_o == '0);

  assert_index_match_R10: assert property (@(posedge clk) disable iff (rst)
    (grant_o != '0) |-> grant_o[grant_idx_o]);

  assert_index_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (grant_o == '0) |-> grant_idx_o == '0);
endmodule

bind slot_share_arbiter slot_share_rules #(.N(N)) u_rules (
  .clk         (clk),
  .rst         (rst),
  .req_i       (req_i),
  .hung_q      (hungry_q),
  .share_off_i (share_off_i),
  .slot        (slot_q),
  .grant_o     (grant_o),
  .grant_idx_o (grant_idx_o)
);

// File: tb/sim_slot_share_arbiter.sv
module sim_slot_share_arbiter;
  localparam int N = 8;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req_i = '0;
  logic [N-1:0] hungry_i = '0;
  logic         share_off_i = 1'b0;
  logic [N-1:0] grant_o;
  logic [W-1:0] grant_idx_o;

  int checks = 0;
  int fails = 0;
  int exp_slot = 0;
  logic [N-1:0] hung_prev = '0;
  bit done = 0;

  always #10 clk = ~clk;

  slot_share_arbiter #(.N(N)) u0 (
    .clk(clk), .rst(rst), .req_i(req_i), .hungry_i(hungry_i),
    .share_off_i(share_off_i), .grant_o(grant_o), .grant_idx_o(grant_idx_o)
  );

  // Reference decision built from R3, R5, R6, R7 and R8.
  function automatic int expect_winner(int slot, logic [N-1:0] rq,
                                       logic [N-1:0] hg, logic off);
    if (rq[slot]) return slot;
    if (off) return -1;
    for (int j = 1; j < N; j++) begin
      int c = (slot + j) % N;
      if (rq[c] && hg[c]) return c;
    end
    return -1;
  endfunction

  task automatic check_out(string tag, int win);
    logic [N-1:0] eg;
    logic [W-1:0] ei;
    eg = (win < 0) ? '0 : (N'(1) << win);
    ei = (win < 0) ? '0 : W'(win);
    checks++;
    if (grant_o !== eg || grant_idx_o !== ei) begin
      fails++;
      $display("FAIL %s: grant=%b idx=%0d expected grant=%b idx=%0d",
               tag, grant_o, grant_idx_o, eg, ei);
    end
  endtask

  // One clock: drive at the falling edge, decide at the rising edge, check at the next falling edge.
  task automatic step(logic [N-1:0] rq, logic [N-1:0] hg, logic off, string tag);
    int win;
    req_i = rq; hungry_i = hg; share_off_i = off;
    win = expect_winner(exp_slot, rq, hung_prev, off);
    @(posedge clk);
    @(negedge clk);
    check_out(tag, win);
    hung_prev = hg;
    exp_slot = (exp_slot + 1) % N;
  endtask

  task automatic do_reset();
    req_i = '0; hungry_i = '0; share_off_i = 1'b0;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_out("R1 reset state", -1);
    rst = 1'b0;
    exp_slot = 0; hung_prev = '0;
  endtask

  task automatic test_rotation();
    do_reset();
    for (int k = 0; k < 2 * N; k++) step('1, '0, 1'b0, "R2 R3 owner rotation");
  endtask

  task automatic test_lone_plain_core();
    do_reset();
    for (int k = 0; k < N; k++) step(8'b0000_1000, '0, 1'b0, "R4 R8 plain core only in own slot");
  endtask

  task automatic test_hungry_fill();
    do_reset();
    step(8'b0000_1000, 8'b0000_1000, 1'b0, "R9 opt-in not yet active");
    for (int k = 0; k < N; k++) step(8'b0000_1000, 8'b0000_1000, 1'b0, "R5 hungry core fills spares");
    step(8'b0000_1000, 8'b0000_0000, 1'b0, "R9 opt-out one step late");
    for (int k = 0; k < 3; k++) step(8'b0000_1000, 8'b0000_0000, 1'b0, "R4 opt-out applied");
  endtask

  task automatic test_owner_beats_hungry();
    do_reset();
    for (int k = 0; k < 2 * N; k++) step(8'b0010_1000, 8'b0000_1000, 1'b0, "R3 R5 owner keeps slot over hungry");
  endtask

  task automatic test_search_order();
    do_reset();
    for (int k = 0; k < 2 * N; k++) step(8'b0100_0100, 8'b0100_0100, 1'b0, "R6 wrapped upward search");
    for (int k = 0; k < N; k++) step(8'b1000_0011, 8'b1000_0011, 1'b0, "R6 wrap past top index");
  endtask

  task automatic test_share_off();
    do_reset();
    step(8'b0001_0001, 8'b0001_0001, 1'b0, "R7 setup");
    for (int k = 0; k < N; k++) step(8'b0001_0001, 8'b0001_0001, 1'b1, "R7 sharing disabled");
    for (int k = 0; k < 3; k++) step(8'b0001_0001, 8'b0001_0001, 1'b0, "R7 sharing restored");
  endtask

  task automatic test_idle();
    do_reset();
    for (int k = 0; k < N; k++) step('0, '1, 1'b0, "R8 R10 all idle");
    step(8'b1000_0000, '1, 1'b0, "R10 single pulse");
    step('0, '1, 1'b0, "R10 grant lasts one cycle");
  endtask

  initial begin
    test_rotation();
    test_lone_plain_core();
    test_hungry_fill();
    test_owner_beats_hungry();
    test_search_order();
    test_share_off();
    test_idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule